// File: doc/BRIEF.md
# Pixel Colour Component Extractor

This block sits between a frame-buffer fetch path and a display output stage. Each incoming pixel word packs between one and four bytes. The block turns it into three 8-bit colour components: red, green and blue. Software programs a pixel-size register and one select register per component. A select register names the lowest source bit, the number of bits to take, and a fallback colour. With these, one block handles many packed pixel layouts, from 8-bit palettised-style words up to 32-bit words with padding.

The fallback colour does three jobs. It is emitted when a component has no bits selected, when the pixel lies in blanking outside the active area, and when the fetch path reports an underrun. Giving red a fallback of all ones and the other components zero therefore paints underrun pixels red. The colour outputs are registered, and a valid flag follows the input valid with the same one-cycle delay.

Top module: `pxu_top`

## Requirements
- R1: After reset, outValid is 0 and all three colour outputs are 0. The configuration is one byte per pixel, and every component has a bit count of 0 and a fallback of 0.
- R2: outValid equals pixValid delayed by one clock. The colour outputs change only on a clock edge where pixValid is 1, and they hold their value otherwise.
- R3: Register address 0 is the pixel size. Its bits [5:3] hold bytes-per-pixel minus one: 0 means 1 byte, 3 means 4 bytes, and codes 4 to 7 also mean 4 bytes. Pixel bits at or above 8 times the byte count read as zero, and the other bits of the write are ignored.
- R4: Register addresses 1, 2 and 3 select the red, green and blue components. Their fields are fallback colour in [23:16], bit count in [11:8] and lowest bit index in [4:0]. All other bits of the write are ignored.
- R5: With a bit count of 8 or more, a component outputs the top 8 bits of its field, which are source bits low+count-1 down to low+count-8. Source bits beyond the 32-bit word read as zero.
- R6: With a bit count from 1 to 7, the field is placed left-aligned in the 8-bit output, and the field is repeated MSB-first to fill the lower bits.
- R7: A component whose bit count is 0 outputs its fallback colour.
- R8: A valid pixel with pixActive low outputs the fallback colour on all three components.
- R9: A valid pixel with pixUnderrun high outputs the fallback colour on all three components, even while active. A red fallback of 0xFF with green and blue fallbacks of 0 yields FF/00/00.
- R10: A register write affects pixels presented on later cycles. A pixel presented in the same cycle as a write uses the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 size, 1 red, 2 green, 3 blue) |
| regWrData | input | 32 | Register write data |
| pixValid | input | 1 | Pixel word present this cycle |
| pixData | input | 32 | Packed pixel word |
| pixActive | input | 1 | Pixel lies inside the active area |
| pixUnderrun | input | 1 | Fetch path could not supply this pixel |
| outValid | output | 1 | Colour outputs carry a new pixel |
| outRed | output | 8 | Red component |
| outGreen | output | 8 | Green component |
| outBlue | output | 8 | Blue component |

## Verification
Extraction is swept over every lowest-bit index and every bit count, under pixel-size codes 0 to 3 plus one out-of-range code. Green and blue are offset from red, so a mix-up between components shows. Two complementary pixel words per setting separate a stuck or swapped source bit from a correct one. The size sweep separates correct zeroing of unused bytes from over- or under-masking. Counts below, at and above 8 separate the replication path from the truncation path. Blanking, underrun, idle cycles and a write that coincides with a pixel show whether the fallback, the hold behaviour and the old-versus-new configuration each apply only where intended.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int NCOMP   = 3;
  localparam int COMP_W  = 8;
  localparam int REG_W   = 32;
  localparam int SIZE_LSB = 3;
  localparam int SIZE_W  = 3;
  localparam int LOW_LSB = 0;
  localparam int LOW_W   = 5;
  localparam int CNT_LSB = 8;
  localparam int CNT_W   = 4;
  localparam int DEF_LSB = 16;

  typedef struct packed {
    logic             sizeWr;
    logic [NCOMP-1:0] selWr;
    logic             capture;
    logic             blank;
  } pxuStrobe_t;
endpackage

// File: rtl/pxu_ctrl.sv
module pxu_ctrl
  import pxu_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              pixValid,
  input  logic              pixActive,
  input  logic              pixUnderrun,
  output pxuStrobe_t        strb,
  output logic              outValid
);
  always_comb begin
    strb.sizeWr  = regWrEn && (regAddr == '0);
    for (int c = 0; c < NCOMP; c++) begin
      strb.selWr[c] = regWrEn && (regAddr == ADDR_W'(c + 1));
    end
    strb.capture = pixValid;
    strb.blank   = !pixActive || pixUnderrun;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= pixValid;
  end
endmodule

// File: rtl/pxu_datapath.sv
module pxu_datapath
  import pxu_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pxuStrobe_t                    strb,
  input  logic [REG_W-1:0]              regWrData,
  input  logic [PIX_W-1:0]              pixData,
  output logic [NCOMP-1:0][COMP_W-1:0]  compOut
);
  localparam int PIX_BYTES = PIX_W / 8;
  localparam int WIDE_W    = PIX_W + (1 << CNT_W);
  localparam int IDX_W     = $clog2(WIDE_W);

  logic [SIZE_W-1:0]                sizeCode;
  logic [NCOMP-1:0][LOW_W-1:0]      selLow;
  logic [NCOMP-1:0][CNT_W-1:0]      selCnt;
  logic [NCOMP-1:0][COMP_W-1:0]     selDef;
  logic [PIX_W-1:0]                 byteMask;
  logic [PIX_W-1:0]                 maskedPix;

  logic unusedWrBits;
  assign unusedWrBits = ^{regWrData[31:24], regWrData[15:12], regWrData[7:6]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sizeCode <= '0;
    else if (strb.sizeWr) sizeCode <= regWrData[SIZE_LSB +: SIZE_W];
  end

  genvar b;
  generate
    for (b = 0; b < PIX_BYTES; b++) begin : g_mask
      assign byteMask[b*8 +: 8] = {8{sizeCode >= SIZE_W'(b)}};
    end
  endgenerate
  assign maskedPix = pixData & byteMask;

  genvar c;
  generate
    for (c = 0; c < NCOMP; c++) begin : g_comp
      logic [WIDE_W-1:0] wide;
      logic [IDX_W-1:0]  pos;
      logic [IDX_W-1:0]  top;
      logic [COMP_W-1:0] fld;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          selLow[c] <= '0;
          selCnt[c] <= '0;
          selDef[c] <= '0;
        end else if (strb.selWr[c]) begin
          selLow[c] <= regWrData[LOW_LSB +: LOW_W];
          selCnt[c] <= regWrData[CNT_LSB +: CNT_W];
          selDef[c] <= regWrData[DEF_LSB +: COMP_W];
        end
      end

      always_comb begin
        wide = WIDE_W'(maskedPix) >> selLow[c];
        fld  = '0;
        top  = (selCnt[c] == '0) ? '0 : IDX_W'(selCnt[c]) - IDX_W'(1);
        pos  = top;
        if (selCnt[c] >= CNT_W'(COMP_W)) begin
          fld = wide[IDX_W'(selCnt[c]) - IDX_W'(COMP_W) +: COMP_W];
        end else begin
          for (int j = COMP_W - 1; j >= 0; j--) begin
            fld[j] = wide[pos];
            pos = (pos == '0) ? top : pos - IDX_W'(1);
          end
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) compOut[c] <= '0;
        else if (strb.capture)
          compOut[c] <= (strb.blank || selCnt[c] == '0) ? selDef[c] : fld;
      end
    end
  endgenerate
endmodule

// File: rtl/pxu_top.sv
module pxu_top
  import pxu_pkg::*;
#(
  parameter int PIX_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic              pixValid,
  input  logic [PIX_W-1:0]  pixData,
  input  logic              pixActive,
  input  logic              pixUnderrun,
  output logic              outValid,
  output logic [7:0]        outRed,
  output logic [7:0]        outGreen,
  output logic [7:0]        outBlue
);
  pxuStrobe_t                   strb;
  logic [NCOMP-1:0][COMP_W-1:0] compOut;

  pxu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .pixValid(pixValid), .pixActive(pixActive), .pixUnderrun(pixUnderrun),
    .strb(strb), .outValid(outValid)
  );

  pxu_datapath #(.PIX_W(PIX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .pixData(pixData), .compOut(compOut)
  );

  assign outRed   = compOut[0];
  assign outGreen = compOut[1];
  assign outBlue  = compOut[2];
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [1:0]  regAddr,
  input logic [31:0] regWrData,
  input logic        pixValid,
  input logic        pixActive,
  input logic        pixUnderrun,
  input logic        outValid,
  input logic [7:0]  outRed,
  input logic [7:0]  outGreen,
  input logic [7:0]  outBlue
);
  logic            armed;
  logic [2:0][7:0] shDef;
  logic [2:0][3:0] shCnt;
  logic            unusedChkBits;
  assign unusedChkBits = ^{regWrData[31:24], regWrData[15:12], regWrData[7:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      shDef <= '0;
      shCnt <= '0;
    end else begin
      armed <= 1'b1;
      for (int c = 0; c < 3; c++) begin
        if (regWrEn && regAddr == 2'(c + 1)) begin
          shDef[c] <= regWrData[23:16];
          shCnt[c] <= regWrData[11:8];
        end
      end
    end
  end

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> outValid == $past(pixValid));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    armed && !$past(pixValid) |-> $stable(outRed) && $stable(outGreen) && $stable(outBlue));

  p_blank_default_r8: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(pixValid && !pixActive) |->
      outRed == $past(shDef[0]) && outGreen == $past(shDef[1]) && outBlue == $past(shDef[2]));

  p_underrun_default_r9: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(pixValid && pixUnderrun) |->
      outRed == $past(shDef[0]) && outGreen == $past(shDef[1]) && outBlue == $past(shDef[2]));

  p_zero_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(pixValid) && $past(shCnt[0]) == 4'd0 |-> outRed == $past(shDef[0]));
endmodule

bind pxu_top pxu_checker u_chk (.*);

// File: tb/tb_pxu_top.sv
module tb_pxu_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        pixValid = 1'b0;
  logic [31:0] pixData = '0;
  logic        pixActive = 1'b0;
  logic        pixUnderrun = 1'b0;
  logic        outValid;
  logic [7:0]  outRed, outGreen, outBlue;

  int checks = 0;
  int errors = 0;
  int mSize = 0;
  int mLow[3];
  int mCnt[3];
  int mDef[3];

  always #4 clk = ~clk;

  pxu_top dut (.*);

  function automatic logic [7:0] extractExp(logic [31:0] pix, int code, int low, int cnt);
    logic [7:0] r;
    int nb, i;
    nb = (code > 3) ? 4 : code + 1;
    r = '0;
    for (int j = 0; j < 8; j++) begin
      i = (cnt >= 8) ? cnt - 8 + j : cnt - 1 - ((7 - j) % cnt);
      r[j] = (low + i < 8 * nb) ? pix[low + i] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [7:0] compExp(int c, logic [31:0] pix, logic blank);
    if (blank || mCnt[c] == 0) return 8'(mDef[c]);
    return extractExp(pix, mSize, mLow[c], mCnt[c]);
  endfunction

  task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic modelWrite(logic [1:0] a, logic [31:0] d);
    if (a == 0) mSize = int'(d[5:3]);
    else begin
      mDef[a-1] = int'(d[23:16]);
      mCnt[a-1] = int'(d[11:8]);
      mLow[a-1] = int'(d[4:0]);
    end
  endtask

  task automatic writeReg(logic [1:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic sendPix(string req, logic [31:0] d, logic act, logic und);
    logic [7:0] eR, eG, eB;
    eR = compExp(0, d, !act || und);
    eG = compExp(1, d, !act || und);
    eB = compExp(2, d, !act || und);
    pixValid = 1'b1; pixData = d; pixActive = act; pixUnderrun = und;
    @(negedge clk);
    pixValid = 1'b0;
    check8("R2", "outValid", {7'b0, outValid}, 8'd1);
    check8(req, "red", outRed, eR);
    check8(req, "green", outGreen, eG);
    check8(req, "blue", outBlue, eB);
  endtask

  task automatic writeSel(int c, int low, int cnt, int def);
    writeReg(2'(c + 1), (32'(def & 255) << 16) | (32'(cnt & 15) << 8) | 32'(low & 31) | 32'hFF00_F0E0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] p;
    logic [7:0] hR, hG, hB;
    for (int c = 0; c < 3; c++) begin mLow[c] = 0; mCnt[c] = 0; mDef[c] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check8("R1", "outValid", {7'b0, outValid}, 8'd0);
    check8("R1", "red", outRed, 8'd0);
    check8("R1", "green", outGreen, 8'd0);
    check8("R1", "blue", outBlue, 8'd0);
    // R1 / R7: default configuration gives zero counts and zero fallbacks
    sendPix("R7", 32'hDEAD_BEEF, 1'b1, 1'b0);

    // R3: junk outside bits [5:3] ignored; 1 byte, upper bytes read zero
    writeReg(2'd0, 32'hFFFF_FFC7);
    writeSel(0, 8, 8, 8'h5A);
    writeSel(1, 0, 8, 0);
    writeSel(2, 4, 8, 0);
    sendPix("R3", 32'hAABB_CCDD, 1'b1, 1'b0);

    // R5 / R6 / R7 / R3 / R4: sweep of size code, low index and count
    for (int code = 0; code < 5; code++) begin
      int sc;
      sc = (code == 4) ? 6 : code;
      writeReg(2'd0, 32'hFFFF_FFC7 | (32'(sc) << 3));
      for (int low = 0; low < 32; low++) begin
        for (int cnt = 0; cnt < 16; cnt++) begin
          writeSel(0, low, cnt, low * 7 + cnt * 13);
          writeSel(1, (low + 7) % 32, (cnt + 3) % 16, low * 3 + 1);
          writeSel(2, (low + 19) % 32, (cnt + 11) % 16, cnt * 17 + 5);
          p = 32'h9E37_79B9 * 32'(low * 16 + cnt + code);
          sendPix(cnt >= 8 ? "R5" : (cnt == 0 ? "R7" : "R6"), p, 1'b1, 1'b0);
          sendPix("R4", ~p, 1'b1, 1'b0);
        end
      end
    end

    // R8: blanking gives fallbacks on all components
    writeReg(2'd0, 32'h0000_0018);
    writeSel(0, 0, 8, 8'h11);
    writeSel(1, 8, 8, 8'h22);
    writeSel(2, 16, 8, 8'h33);
    sendPix("R8", 32'h0102_0304, 1'b0, 1'b0);
    sendPix("R8", 32'h0102_0304, 1'b1, 1'b0);

    // R9: underrun while active shows red
    writeSel(0, 0, 8, 8'hFF);
    writeSel(1, 8, 8, 8'h00);
    writeSel(2, 16, 8, 8'h00);
    sendPix("R9", 32'h0055_6677, 1'b1, 1'b1);
    check8("R9", "red underrun", outRed, 8'hFF);
    check8("R9", "green underrun", outGreen, 8'h00);

    // R2: idle cycles hold the colour outputs
    sendPix("R2", 32'h00C3_A55A, 1'b1, 1'b0);
    hR = outRed; hG = outGreen; hB = outBlue;
    pixData = 32'hFFFF_FFFF; pixActive = 1'b0; pixUnderrun = 1'b1;
    repeat (2) @(negedge clk);
    check8("R2", "outValid idle", {7'b0, outValid}, 8'd0);
    check8("R2", "red hold", outRed, hR);
    check8("R2", "green hold", outGreen, hG);
    check8("R2", "blue hold", outBlue, hB);

    // R10: write coinciding with a pixel uses old configuration
    begin
      logic [7:0] eR;
      eR = compExp(0, 32'h0000_00F0, 1'b0);
      regWrEn = 1'b1; regAddr = 2'd1; regWrData = 32'h0000_0404;
      pixValid = 1'b1; pixData = 32'h0000_00F0; pixActive = 1'b1; pixUnderrun = 1'b0;
      @(negedge clk);
      regWrEn = 1'b0; pixValid = 1'b0;
      check8("R10", "red same-cycle", outRed, eR);
      modelWrite(2'd1, 32'h0000_0404);
      sendPix("R10", 32'h0000_00F0, 1'b1, 1'b0);
      check8("R10", "red next pixel", outRed, 8'hFF);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule